// File: doc/BRIEF.md
# LUT Brightness Ramp Sequencer

This block plays brightness patterns out of a small shared lookup table and hands one duty value per channel to a downstream PWM generator. Every channel walks its own window of the table, marked by a low and a high index. It spends a programmable number of millisecond ticks on each entry. At the ends of the window it can pause for a whole number of steps. After that it either turns back (ping-pong) or jumps to the opposite end. In one-shot mode it stops after a single pass instead.

Software writes the table, the per-channel window, step length, pause counts and mode flags through one write port. It then launches any set of channels on the same clock edge by writing a bitmask. The pace comes from a one-cycle `tick_en` pulse per millisecond, so the block is independent of the system clock frequency. Each channel reports its current duty value, a strobe whenever a new entry is loaded, a busy flag while it plays and a done flag once a one-shot pass has ended.

Top module: `lramp_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, every channel shows busy 0, done 0, strobe 0 and duty 0. After reset each channel's step register holds 1 and every other setting holds 0.
- R2: A write of mask M to address 0x70 starts, on that clock edge, every channel c whose bit M[c] is 1. Channels whose bit is 0 keep their state and outputs unchanged.
- R3: Mode bit 4 selects the starting end and the direction. When it is 1, play starts at the low index and moves up. When it is 0, play starts at the high index and moves down.
- R4: Each entry stays on the duty output for exactly S tick pulses, where S is the 9-bit step register and S = 0 counts as 1. Cycles without a tick pulse never advance play.
- R5: With mode bit 3 = 1 (repeat) and bit 2 = 0, the step after the last entry of a pass loads the starting end again (low when moving up, high when moving down).
- R6: With mode bits 3 and 2 both 1 (ping-pong), reaching the high end while moving up turns play downward to high-1. Reaching the low end while moving down turns play upward to low+1. The end entry is not repeated.
- R7: In repeat mode, mode bit 1 adds a pause of P_hi x S ticks after the entry at the high end when play moves up. Mode bit 0 adds a pause of P_lo x S ticks after the entry at the low end when play moves down. A cleared bit, or a count of 0, gives no pause.
- R8: With mode bit 3 = 0 (one-shot), busy drops and done rises once the last entry of the pass has had its S ticks. The duty output keeps that entry's value. Done stays set until the channel is started again, and busy and done are never 1 together.
- R9: The strobe is high for exactly one cycle each time a new entry is loaded onto the duty output: at start, on each step, and on each wrap or turn. It is never high while busy is 0.
- R10: When the low index equals the high index, play covers the whole table, from index 0 to LUT_DEPTH-1.
- R11: The write map is as follows. Table entry i is at address 0x80+i and stores the low 9 data bits. Channel c register r is at address c*16+r, where r = 0 is mode, 1 the low index, 2 the high index, 3 the step, 4 P_hi and 5 P_lo. A table write reaches the duty output only when the entry is next loaded.
- R12: A start written to a channel that is already playing restarts it from its starting end with the step and pause counts cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per millisecond tick |
| wr_en | input | 1 | Register or table write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| duty_o | output | NUM_CH x DUTY_W | Current duty value per channel |
| duty_stb_o | output | NUM_CH | New-entry strobe per channel |
| busy_o | output | NUM_CH | Channel is playing |
| done_o | output | NUM_CH | One-shot pass has completed |

## Verification
The bench drives four kinds of play:
- An upward and a downward repeating loop in different windows, which separate start-end selection from wrap behaviour.
- A ping-pong window with both pauses enabled, and the same window with the pause bits cleared but the counts left nonzero. Together these separate turn-around timing from pause gating.
- A one-shot pass followed by a restart, which shows the hold of the final value and the clearing of done.
- A full-table sweep from equal indices, a step of three with long idle gaps between ticks, and a step of zero. These pin down both the pace and its tick dependence.

A behavioural model is compared against every output on every clock. Mid-play restarts, single-channel masks and table rewrites check that unrelated state is left untouched.

// File: rtl/lramp_pkg.sv
// Package: shared constants for the LUT ramp sequencer.
// Assumes an 8-bit write address space split into a table half and a
// channel-register half.
package lramp_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 8;

    // Mode flags; bit positions are software-visible
    typedef struct packed {
        logic up;      // bit 4: start at low index and move up
        logic rpt;     // bit 3: loop forever
        logic pp;      // bit 2: ping-pong turn-around
        logic p_hi;    // bit 1: pause at high end
        logic p_lo;    // bit 0: pause at low end
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam logic [3:0] REG_MODE = 4'd0;
    localparam logic [3:0] REG_LO   = 4'd1;
    localparam logic [3:0] REG_HI   = 4'd2;
    localparam logic [3:0] REG_STEP = 4'd3;
    localparam logic [3:0] REG_PHI  = 4'd4;
    localparam logic [3:0] REG_PLO  = 4'd5;

    localparam logic [ADDR_W-1:0] START_ADDR = 8'h70;

endpackage

// File: rtl/lramp_cfg.sv
// Module: configuration store and brightness table for the ramp sequencer.
// Decodes the write port into per-channel settings, the shared table and a
// combinational start vector. Assumes NUM_CH <= 7 (group 7 holds the start
// register) and LUT_DEPTH <= 128.
module lramp_cfg
    import lramp_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 16,
    parameter int DUTY_W    = 9,
    parameter int STEP_W    = 9,
    parameter int PAUSE_W   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [DATA_W-1:0]                      wr_data,
    output mode_t [NUM_CH-1:0]                     mode_o,
    output logic  [NUM_CH-1:0][IDX_W-1:0]          lo_o,
    output logic  [NUM_CH-1:0][IDX_W-1:0]          hi_o,
    output logic  [NUM_CH-1:0][STEP_W-1:0]         step_o,
    output logic  [NUM_CH-1:0][PAUSE_W-1:0]        phi_o,
    output logic  [NUM_CH-1:0][PAUSE_W-1:0]        plo_o,
    output logic  [LUT_DEPTH-1:0][DUTY_W-1:0]      lut_o,
    output logic  [NUM_CH-1:0]                     start_o
);

    localparam int GRP_W = 3;

    logic                tbl_sel;
    logic [GRP_W-1:0]    grp;
    logic [3:0]          rsel;
    logic                unused_data;

    assign tbl_sel     = wr_addr[ADDR_W-1];
    assign grp         = wr_addr[6:4];
    assign rsel        = wr_addr[3:0];
    assign unused_data = ^wr_data;

    // Start vector: one write launches all selected channels together
    always_comb begin
        start_o = '0;
        if (wr_en && wr_addr == START_ADDR) start_o = wr_data[NUM_CH-1:0];
    end

    for (genvar e = 0; e < LUT_DEPTH; e++) begin : g_lut
        // Table entry e: written at 0x80+e
        always_ff @(posedge clk) begin
            if (!rst_n)                                   lut_o[e] <= '0;
            else if (wr_en && tbl_sel &&
                     wr_addr[ADDR_W-2:0] == (ADDR_W-1)'(e)) lut_o[e] <= wr_data[DUTY_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && !tbl_sel && grp == GRP_W'(c);

        // Per-channel settings, one register per address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_o[c] <= '0;
                lo_o[c]   <= '0;
                hi_o[c]   <= '0;
                step_o[c] <= STEP_W'(1);
                phi_o[c]  <= '0;
                plo_o[c]  <= '0;
            end else if (hit) begin
                case (rsel)
                    REG_MODE: mode_o[c] <= mode_t'(wr_data[MODE_W-1:0]);
                    REG_LO:   lo_o[c]   <= wr_data[IDX_W-1:0];
                    REG_HI:   hi_o[c]   <= wr_data[IDX_W-1:0];
                    REG_STEP: step_o[c] <= wr_data[STEP_W-1:0];
                    REG_PHI:  phi_o[c]  <= wr_data[PAUSE_W-1:0];
                    REG_PLO:  plo_o[c]  <= wr_data[PAUSE_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/lramp_chan.sv
// Module: one playback channel of the ramp sequencer.
// Walks a table window at tick_en pace, applying end pauses, wrap or
// ping-pong turn-around, or one-shot stop. Assumes LUT_DEPTH is a power of
// two, so the low index bits always address a real entry.
module lramp_chan
    import lramp_pkg::*;
#(
    parameter int LUT_DEPTH = 16,
    parameter int DUTY_W    = 9,
    parameter int STEP_W    = 9,
    parameter int PAUSE_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_en,
    input  logic                              start,
    input  mode_t                             mode,
    input  logic [IDX_W-1:0]                  lo_raw,
    input  logic [IDX_W-1:0]                  hi_raw,
    input  logic [STEP_W-1:0]                 step,
    input  logic [PAUSE_W-1:0]                p_hi,
    input  logic [PAUSE_W-1:0]                p_lo,
    input  logic [LUT_DEPTH-1:0][DUTY_W-1:0]  lut,
    output logic [DUTY_W-1:0]                 duty,
    output logic                              stb,
    output logic                              busy,
    output logic                              done
);

    localparam int               LUT_AW   = $clog2(LUT_DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LUT_DEPTH - 1);

    logic [IDX_W-1:0]   idx, lo_c, hi_c, win_lo, win_hi;
    logic [IDX_W-1:0]   start_idx, step_idx, wrap_idx, ld_idx;
    logic               up, wrap_up, ld_up, ld, stop, pause_ld;
    logic               at_end, last_tick, pause_en;
    logic [STEP_W-1:0]  tcnt, step_e;
    logic [PAUSE_W-1:0] pcnt, pause_val;

    // Window limits: clamp to the table, equal or inverted means full sweep
    always_comb begin
        lo_c = (lo_raw > LAST_IDX) ? LAST_IDX : lo_raw;
        hi_c = (hi_raw > LAST_IDX) ? LAST_IDX : hi_raw;
        if (lo_c >= hi_c) begin
            win_lo = '0;
            win_hi = LAST_IDX;
        end else begin
            win_lo = lo_c;
            win_hi = hi_c;
        end
    end

    // Next-index candidates for start, plain step and end-of-pass
    always_comb begin
        step_e    = (step == '0) ? STEP_W'(1) : step;
        last_tick = (tcnt == step_e - STEP_W'(1));
        at_end    = up ? (idx == win_hi) : (idx == win_lo);
        start_idx = mode.up ? win_lo : win_hi;
        step_idx  = up ? idx + IDX_W'(1) : idx - IDX_W'(1);
        pause_en  = up ? mode.p_hi : mode.p_lo;
        pause_val = up ? p_hi : p_lo;
        if (mode.pp) begin
            wrap_up  = !up;
            wrap_idx = up ? win_hi - IDX_W'(1) : win_lo + IDX_W'(1);
        end else begin
            wrap_up  = up;
            wrap_idx = up ? win_lo : win_hi;
        end
    end

    // Event decode: load a new entry, enter a pause, or stop a one-shot pass
    always_comb begin
        ld       = 1'b0;
        ld_idx   = idx;
        ld_up    = up;
        stop     = 1'b0;
        pause_ld = 1'b0;
        if (start) begin
            ld     = 1'b1;
            ld_idx = start_idx;
            ld_up  = mode.up;
        end else if (busy && tick_en && last_tick) begin
            if (pcnt == PAUSE_W'(1)) begin
                ld     = 1'b1;
                ld_idx = wrap_idx;
                ld_up  = wrap_up;
            end else if (pcnt == '0) begin
                if (at_end) begin
                    if (!mode.rpt) begin
                        stop = 1'b1;
                    end else if (pause_en && pause_val != '0) begin
                        pause_ld = 1'b1;
                    end else begin
                        ld     = 1'b1;
                        ld_idx = wrap_idx;
                        ld_up  = wrap_up;
                    end
                end else begin
                    ld     = 1'b1;
                    ld_idx = step_idx;
                end
            end
        end
    end

    // Output and position registers: updated on each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            up   <= 1'b0;
            duty <= '0;
            stb  <= 1'b0;
        end else begin
            stb <= ld;
            if (ld) begin
                idx  <= ld_idx;
                up   <= ld_up;
                duty <= lut[ld_idx[LUT_AW-1:0]];
            end
        end
    end

    // Run state and pace counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            tcnt <= '0;
            pcnt <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            tcnt <= '0;
            pcnt <= '0;
        end else if (busy && tick_en) begin
            tcnt <= last_tick ? '0 : tcnt + STEP_W'(1);
            if (last_tick) begin
                if (pcnt != '0)    pcnt <= pcnt - PAUSE_W'(1);
                else if (pause_ld) pcnt <= pause_val;
            end
            if (stop) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lramp_seq.sv
// Module: top of the LUT-driven brightness ramp sequencer.
// Joins the shared configuration store to NUM_CH playback channels.
// Assumes tick_en is a single-cycle pulse per millisecond.
module lramp_seq
    import lramp_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 16,
    parameter int DUTY_W    = 9,
    parameter int STEP_W    = 9,
    parameter int PAUSE_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_en,
    input  logic                           wr_en,
    input  logic [7:0]                     wr_addr,
    input  logic [15:0]                    wr_data,
    output logic [NUM_CH-1:0][DUTY_W-1:0]  duty_o,
    output logic [NUM_CH-1:0]              duty_stb_o,
    output logic [NUM_CH-1:0]              busy_o,
    output logic [NUM_CH-1:0]              done_o
);

    mode_t [NUM_CH-1:0]                 mode;
    logic  [NUM_CH-1:0][IDX_W-1:0]      lo, hi;
    logic  [NUM_CH-1:0][STEP_W-1:0]     step;
    logic  [NUM_CH-1:0][PAUSE_W-1:0]    phi, plo;
    logic  [LUT_DEPTH-1:0][DUTY_W-1:0]  lut;
    logic  [NUM_CH-1:0]                 start;

    lramp_cfg #(
        .NUM_CH(NUM_CH), .LUT_DEPTH(LUT_DEPTH), .DUTY_W(DUTY_W),
        .STEP_W(STEP_W), .PAUSE_W(PAUSE_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_o(mode), .lo_o(lo), .hi_o(hi),
        .step_o(step), .phi_o(phi), .plo_o(plo), .lut_o(lut),
        .start_o(start)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        lramp_chan #(
            .LUT_DEPTH(LUT_DEPTH), .DUTY_W(DUTY_W),
            .STEP_W(STEP_W), .PAUSE_W(PAUSE_W)
        ) chan_i (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start[c]),
            .mode(mode[c]), .lo_raw(lo[c]), .hi_raw(hi[c]), .step(step[c]),
            .p_hi(phi[c]), .p_lo(plo[c]), .lut(lut),
            .duty(duty_o[c]), .stb(duty_stb_o[c]),
            .busy(busy_o[c]), .done(done_o[c])
        );
    end

endmodule

// File: rtl/lramp_seq_chk.sv
// Module: property checker for the ramp sequencer, bound to lramp_seq.
// Observes ports only.
module lramp_seq_chk #(
    parameter int NUM_CH = 3,
    parameter int DUTY_W = 9
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           tick_en,
    input logic                           wr_en,
    input logic [7:0]                     wr_addr,
    input logic [15:0]                    wr_data,
    input logic [NUM_CH-1:0][DUTY_W-1:0]  duty_o,
    input logic [NUM_CH-1:0]              duty_stb_o,
    input logic [NUM_CH-1:0]              busy_o,
    input logic [NUM_CH-1:0]              done_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R2
        start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == 8'h70 && wr_data[c]) |=> (busy_o[c] && duty_stb_o[c]));
        // R4
        quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(tick_en) && !$past(wr_en)) |-> ($stable(duty_o[c]) && $stable(busy_o[c])));
        // R8
        busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(busy_o[c] && done_o[c]));
        // R8
        stop_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy_o[c]) |-> done_o[c]);
        // R9
        stb_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            duty_stb_o[c] |-> busy_o[c]);
        // R9
        duty_only_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !duty_stb_o[c] |-> $stable(duty_o[c]));
    end

endmodule

bind lramp_seq lramp_seq_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .duty_o(duty_o),
    .duty_stb_o(duty_stb_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/lramp_seq_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks at hand-computed points.
module lramp_seq_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NCH = 3;
    localparam int DEP = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  tick_en = 1'b0;
    logic                  wr_en = 1'b0;
    logic [7:0]            wr_addr = '0;
    logic [15:0]           wr_data = '0;
    logic [NCH-1:0][8:0]   duty_o;
    logic [NCH-1:0]        duty_stb_o, busy_o, done_o;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    lramp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .duty_o(duty_o),
        .duty_stb_o(duty_stb_o), .busy_o(busy_o), .done_o(done_o)
    );

    // ---------------- reference model ----------------
    int m_lut[DEP];
    int m_mode[NCH], m_lo[NCH], m_hi[NCH], m_step[NCH], m_phi[NCH], m_plo[NCH];
    int s_busy[NCH], s_done[NCH], s_up[NCH], s_idx[NCH];
    int s_duty[NCH], s_stb[NCH], s_t[NCH], s_p[NCH];

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic load(int c, int i);
        s_idx[c]  = i & 255;
        s_duty[c] = m_lut[s_idx[c] % DEP];
        s_stb[c]  = 1;
    endtask

    task automatic model_chan(int c, bit st);
        int lo, hi, sp, pen, pv;
        bit ate;
        lo = mn(m_lo[c], DEP - 1);
        hi = mn(m_hi[c], DEP - 1);
        if (lo >= hi) begin lo = 0; hi = DEP - 1; end
        sp = (m_step[c] == 0) ? 1 : m_step[c];
        s_stb[c] = 0;
        if (st) begin
            s_busy[c] = 1; s_done[c] = 0; s_t[c] = 0; s_p[c] = 0;
            s_up[c] = (m_mode[c] >> 4) & 1;
            load(c, s_up[c] ? lo : hi);
        end else if (s_busy[c] != 0 && tick_en) begin
            if (s_t[c] + 1 < sp) s_t[c]++;
            else begin
                s_t[c] = 0;
                ate = s_up[c] ? (s_idx[c] == hi) : (s_idx[c] == lo);
                pen = s_up[c] ? ((m_mode[c] >> 1) & 1) : (m_mode[c] & 1);
                pv  = s_up[c] ? m_phi[c] : m_plo[c];
                if (s_p[c] > 1) s_p[c]--;
                else if (s_p[c] == 1 || ate) begin
                    if (s_p[c] == 0 && ((m_mode[c] >> 3) & 1) == 0) begin
                        s_busy[c] = 0; s_done[c] = 1;
                    end else if (s_p[c] == 0 && pen != 0 && pv > 0) begin
                        s_p[c] = pv;
                    end else begin
                        s_p[c] = 0;
                        if ((m_mode[c] >> 2) & 1) begin
                            load(c, s_up[c] ? hi - 1 : lo + 1);
                            s_up[c] = 1 - s_up[c];
                        end else load(c, s_up[c] ? lo : hi);
                    end
                end else load(c, s_up[c] ? s_idx[c] + 1 : s_idx[c] - 1);
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_mode[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_step[c] = 1;
                m_phi[c] = 0; m_plo[c] = 0;
                s_busy[c] = 0; s_done[c] = 0; s_up[c] = 0; s_idx[c] = 0;
                s_duty[c] = 0; s_stb[c] = 0; s_t[c] = 0; s_p[c] = 0;
            end
            for (int e = 0; e < DEP; e++) m_lut[e] = 0;
        end else begin
            for (int c = 0; c < NCH; c++)
                model_chan(c, wr_en && wr_addr == 8'h70 && wr_data[c]);
            if (wr_en) begin
                if (wr_addr[7]) begin
                    if (wr_addr[6:0] < DEP) m_lut[wr_addr[6:0]] = wr_data[8:0];
                end else if (wr_addr[6:4] < NCH) begin
                    case (wr_addr[3:0])
                        4'd0: m_mode[wr_addr[6:4]] = wr_data[4:0];
                        4'd1: m_lo[wr_addr[6:4]]   = wr_data[7:0];
                        4'd2: m_hi[wr_addr[6:4]]   = wr_data[7:0];
                        4'd3: m_step[wr_addr[6:4]] = wr_data[8:0];
                        4'd4: m_phi[wr_addr[6:4]]  = wr_data[7:0];
                        4'd5: m_plo[wr_addr[6:4]]  = wr_data[7:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            chk(cur_req, $sformatf("ch%0d duty", c), int'(duty_o[c]), s_duty[c]);
            chk(cur_req, $sformatf("ch%0d strobe", c), int'(duty_stb_o[c]), s_stb[c]);
            chk(cur_req, $sformatf("ch%0d busy", c), int'(busy_o[c]), s_busy[c]);
            chk(cur_req, $sformatf("ch%0d done", c), int'(done_o[c]), s_done[c]);
        end
    end

    // ---------------- stimulus helpers (called at negedge) ----------------
    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(int c, int mode, int lo, int hi, int st, int ph, int pl);
        wr(c * 16 + 0, mode); wr(c * 16 + 1, lo); wr(c * 16 + 2, hi);
        wr(c * 16 + 3, st);   wr(c * 16 + 4, ph); wr(c * 16 + 5, pl);
    endtask

    task automatic go(int mask);
        wr(8'h70, mask);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    function automatic int lv(int i);
        return 10 * i + 5;
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            chk("R1", "reset busy", int'(busy_o[c]), 0);
            chk("R1", "reset done", int'(done_o[c]), 0);
            chk("R1", "reset duty", int'(duty_o[c]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset strobe", int'(duty_stb_o[0]), 0);

        cur_req = "R11";
        for (int e = 0; e < DEP; e++) wr(8'h80 + e, lv(e));

        // Up and down repeating loops
        cur_req = "R3";
        cfg(0, 8'h18, 2, 5, 2, 0, 0);
        cfg(1, 8'h08, 3, 6, 1, 0, 0);
        go(3);
        chk("R3", "ch0 starts at low", int'(duty_o[0]), lv(2));
        chk("R3", "ch1 starts at high", int'(duty_o[1]), lv(6));
        chk("R2", "ch0 busy after mask", int'(busy_o[0]), 1);
        chk("R2", "ch2 not started", int'(busy_o[2]), 0);
        chk("R9", "strobe at start", int'(duty_stb_o[0]), 1);
        @(negedge clk);
        chk("R9", "strobe one cycle", int'(duty_stb_o[0]), 0);
        cur_req = "R4";
        ticks(1);
        chk("R4", "ch0 held for step 2", int'(duty_o[0]), lv(2));
        chk("R3", "ch1 moves down", int'(duty_o[1]), lv(5));
        ticks(1);
        chk("R4", "ch0 advances after 2", int'(duty_o[0]), lv(3));
        cur_req = "R5";
        ticks(6);
        chk("R5", "ch0 wraps to low", int'(duty_o[0]), lv(2));
        chk("R5", "ch1 wraps to high", int'(duty_o[1]), lv(6));

        // Ping-pong with pauses
        cur_req = "R6";
        cfg(0, 8'h1F, 1, 3, 1, 2, 1);
        go(1);
        chk("R6", "pp start", int'(duty_o[0]), lv(1));
        ticks(2);
        chk("R6", "pp reaches high", int'(duty_o[0]), lv(3));
        ticks(2);
        chk("R7", "high pause holds", int'(duty_o[0]), lv(3));
        ticks(1);
        chk("R6", "pp turns down", int'(duty_o[0]), lv(2));
        ticks(2);
        chk("R7", "low pause holds", int'(duty_o[0]), lv(1));
        ticks(1);
        chk("R6", "pp turns up", int'(duty_o[0]), lv(2));

        // Pause bits cleared, counts nonzero
        cur_req = "R7";
        cfg(0, 8'h1C, 1, 3, 1, 2, 1);
        go(1);
        ticks(3);
        chk("R7", "no pause when bit clear", int'(duty_o[0]), lv(2));

        // One-shot and restart
        cur_req = "R8";
        cfg(2, 8'h10, 4, 6, 1, 0, 0);
        go(4);
        ticks(2);
        chk("R8", "one-shot at last entry busy", int'(busy_o[2]), 1);
        ticks(1);
        chk("R8", "one-shot busy cleared", int'(busy_o[2]), 0);
        chk("R8", "one-shot done", int'(done_o[2]), 1);
        chk("R8", "one-shot holds last", int'(duty_o[2]), lv(6));
        ticks(2);
        chk("R8", "still held", int'(duty_o[2]), lv(6));
        go(4);
        chk("R8", "restart clears done", int'(done_o[2]), 0);
        chk("R12", "restart duty", int'(duty_o[2]), lv(4));

        // Full sweep from equal indices
        cur_req = "R10";
        cfg(1, 8'h18, 7, 7, 1, 0, 0);
        go(2);
        chk("R10", "full sweep starts at 0", int'(duty_o[1]), lv(0));
        ticks(15);
        chk("R10", "full sweep reaches last", int'(duty_o[1]), lv(DEP - 1));
        ticks(1);
        chk("R10", "full sweep wraps", int'(duty_o[1]), lv(0));

        // Step of three, idle gaps, step zero
        cur_req = "R4";
        cfg(0, 8'h18, 0, 2, 3, 0, 0);
        go(1);
        ticks(2);
        chk("R4", "step 3 not yet", int'(duty_o[0]), lv(0));
        repeat (10) @(negedge clk);
        chk("R4", "idle cycles ignored", int'(duty_o[0]), lv(0));
        ticks(1);
        chk("R4", "step 3 advances", int'(duty_o[0]), lv(1));
        cfg(0, 8'h18, 0, 2, 0, 0, 0);
        go(1);
        ticks(1);
        chk("R4", "step 0 acts as 1", int'(duty_o[0]), lv(1));

        // Restart mid-play
        cur_req = "R12";
        go(1);
        chk("R12", "restart from low", int'(duty_o[0]), lv(0));
        chk("R12", "restart busy", int'(busy_o[0]), 1);

        // Table rewrite reaches output only on load
        cur_req = "R11";
        wr(8'h80, 300);
        chk("R11", "table write not applied yet", int'(duty_o[0]), lv(0));
        go(1);
        chk("R11", "new table value on load", int'(duty_o[0]), 300);

        // Single-channel mask leaves others alone
        cur_req = "R2";
        held = int'(duty_o[1]);
        go(4);
        chk("R2", "ch1 duty untouched", int'(duty_o[1]), held);
        chk("R2", "ch1 still busy", int'(busy_o[1]), 1);
        ticks(4);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule